// File: doc/BRIEF.md
# Four-Source Priority Interrupt Controller

This controller gathers interrupt requests from four source classes (hardware failure, program fault, timer and I/O), latches each rising request edge as a pending bit, and presents one request at a time to a processor over a single request line. The request carries the 2-bit number of the chosen source. The processor takes it with an acknowledge pulse and later closes the handler with an end-of-service pulse.

A mode input selects how requests are issued while a handler runs. In sequential mode nothing new is issued while a handler is in service. Requests that arrive in the meantime stay pending, and they are issued later in the order they arrived. In nested mode a strictly higher-priority source may preempt the running handler. The controller keeps an in-service vector as a level stack. End-of-service retires the highest level, so the interrupted lower level is active again and governs preemption.

The controller is a three-state machine:
- Idle: nothing is requested and nothing is in service.
- Asking: the request line is high.
- Busy: at least one level is in service and no request is out.

Transitions:
- Idle goes to Asking when a candidate exists.
- Asking goes to Busy on acknowledge.
- Busy goes to Idle on end-of-service of the last level.
- Busy goes to Asking in nested mode when a higher-priority candidate exists.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request line is low and no source is pending or in service.
- R2: A rising edge on a request input makes that source pending. A level held high does not re-trigger. The pending bit clears when that source is acknowledged.
- R3: From Idle, a request edge sampled at clock edge t raises the request line after clock edge t+1. The source number then stays constant until acknowledge, and the line is low after the clock edge that samples the acknowledge.
- R4: Source numbers are bit indices of the request input: 3 is hardware failure, 2 is program fault, 1 is timer and 0 is I/O. A larger number means higher priority.
- R5: In sequential mode no request is issued while a source is in service. Sources that became pending are issued after end-of-service, in the order their edges arrived.
- R6: In sequential mode, edges that arrive in the same cycle are queued highest number first.
- R7: In nested mode a pending source is issued only if its number exceeds every in-service level. Otherwise it waits.
- R8: In nested mode end-of-service retires only the highest in-service level. The remaining highest level then sets the preemption threshold.
- R9: Acknowledge while the request line is low, and end-of-service with nothing in service, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 4 | Request lines, bit index = source number |
| nest_mode | input | 1 | 1 = nested preemption, 0 = sequential |
| irq_ack | input | 1 | Processor acknowledge of the current request |
| svc_done | input | 1 | End of the running handler |
| irq_out | output | 1 | Request to the processor |
| irq_id | output | 2 | Number of the requested source |

## Verification
A pending bit appears one clock after the edge. The request line follows one clock later. The line falls one clock after acknowledge. A queued sequential request reappears two clocks after end-of-service. The bench drives and samples only on falling clock edges. For the exact R3 latency it samples at those clocks, and elsewhere it polls with a bounded wait that also checks the line stays low for several cycles in blocked cases. Expected issue orders come from the stimulus itself: descending bit order for same-cycle masks, drive order for staggered permutations, and a comparison of the two numbers for nested pairs.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ASK,
        ST_BUSY
    } irq_state_e;
endpackage

// File: rtl/edge_capture.sv
module edge_capture #(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   src,
    input  logic           clr_en,
    input  logic [IDW-1:0] clr_id,
    output logic [N-1:0]   pend,
    output logic [N-1:0]   push
);
    logic [N-1:0] src_q;
    logic [N-1:0] rise;
    logic [N-1:0] clr_mask;

    assign rise     = src & ~src_q;
    assign push     = rise & ~pend;
    assign clr_mask = clr_en ? (N'(1) << clr_id) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            pend  <= '0;
        end else begin
            src_q <= src;
            pend  <= (pend | rise) & ~clr_mask;
        end
    end
endmodule

// File: rtl/arrival_queue.sv
module arrival_queue #(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   push,
    input  logic           del_en,
    input  logic [IDW-1:0] del_id,
    output logic [IDW-1:0] head,
    output logic           head_v
);
    localparam int CW = $clog2(N + 1);

    logic [IDW-1:0] q  [N];
    logic [IDW-1:0] nq [N];
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  ncnt;
    logic           found;

    always_comb begin
        nq    = q;
        ncnt  = cnt;
        found = 1'b0;
        if (del_en) begin
            for (int i = 0; i < N; i++) begin
                if (!found && (CW'(i) < cnt) && (q[i] == del_id))
                    found = 1'b1;
                if (found)
                    nq[i] = q[(i + 1) % N];
            end
            if (found)
                ncnt = ncnt - CW'(1);
        end
        for (int s = N - 1; s >= 0; s--) begin
            if (push[s] && (ncnt < CW'(N))) begin
                nq[ncnt[IDW-1:0]] = IDW'(s);
                ncnt = ncnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < N; i++) q[i] <= '0;
        end else begin
            cnt <= ncnt;
            q   <= nq;
        end
    end

    assign head   = q[0];
    assign head_v = (cnt != '0);
endmodule

// File: rtl/in_service_track.sv
module in_service_track #(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_en,
    input  logic [IDW-1:0] set_id,
    input  logic           done,
    output logic [N-1:0]   isr,
    output logic [IDW-1:0] top,
    output logic           any,
    output logic           single
);
    logic [N-1:0] isr_n;

    always_comb begin
        top = '0;
        for (int i = 0; i < N; i++)
            if (isr[i]) top = IDW'(i);
    end

    assign any    = |isr;
    assign single = $onehot(isr);

    always_comb begin
        isr_n = isr;
        if (done && any) isr_n[top] = 1'b0;
        if (set_en)      isr_n[set_id] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) isr <= '0;
        else        isr <= isr_n;
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           src_req,
    input  logic                      nest_mode,
    input  logic                      irq_ack,
    input  logic                      svc_done,
    output logic                      irq_out,
    output logic [$clog2(NSRC)-1:0]   irq_id
);
    localparam int IDW = $clog2(NSRC);

    irq_state_e     state, state_n;
    logic [IDW-1:0] id_q;
    logic [NSRC-1:0] pend_w, push_w, isr_w;
    logic [IDW-1:0] head, isr_top, hp, cand_id;
    logic           head_v, isr_any, isr_single, cand_v, nest_ok, take;

    assign take = (state == ST_ASK) && irq_ack;

    edge_capture #(.N(NSRC), .IDW(IDW)) u_edge (
        .clk(clk), .rst_n(rst_n), .src(src_req),
        .clr_en(take), .clr_id(id_q), .pend(pend_w), .push(push_w)
    );

    arrival_queue #(.N(NSRC), .IDW(IDW)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(push_w),
        .del_en(take), .del_id(id_q), .head(head), .head_v(head_v)
    );

    in_service_track #(.N(NSRC), .IDW(IDW)) u_isr (
        .clk(clk), .rst_n(rst_n), .set_en(take), .set_id(id_q),
        .done(svc_done), .isr(isr_w), .top(isr_top),
        .any(isr_any), .single(isr_single)
    );

    // highest pending source number
    always_comb begin
        hp = '0;
        for (int i = 0; i < NSRC; i++)
            if (pend_w[i]) hp = IDW'(i);
    end

    assign nest_ok = (|pend_w) && (!isr_any || (hp > isr_top));
    assign cand_v  = nest_mode ? nest_ok : head_v;
    assign cand_id = nest_mode ? hp : head;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (cand_v) state_n = ST_ASK;
            ST_ASK:  if (irq_ack) state_n = ST_BUSY;
            ST_BUSY: begin
                if (svc_done && isr_single)   state_n = ST_IDLE;
                else if (nest_mode && cand_v) state_n = ST_ASK;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  id_q <= '0;
        else if (state != ST_ASK && state_n == ST_ASK) id_q <= cand_id;
    end

    assign irq_out = (state == ST_ASK);
    assign irq_id  = id_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int N = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 nest_mode,
    input logic                 irq_out,
    input logic [$clog2(N)-1:0] irq_id,
    input logic                 irq_ack,
    input logic                 svc_done,
    input logic [N-1:0]         pend,
    input logic [N-1:0]         in_svc
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !irq_out);

    assert_id_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out && !irq_ack |=> irq_out && $stable(irq_id));

    assert_drop_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out && irq_ack |=> !irq_out);

    assert_pend_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out && irq_ack |=> !pend[$past(irq_id)]);

    assert_seq_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !nest_mode && (in_svc != '0) |-> !irq_out);

    assert_seq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !nest_mode |-> $onehot0(in_svc));

    assert_nest_higher_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nest_mode && irq_out |-> ((in_svc >> irq_id) == '0));

    assert_stray_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out && irq_ack && !svc_done |=> $stable(in_svc));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N(NSRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .nest_mode(nest_mode), .irq_out(irq_out),
    .irq_id(irq_id), .irq_ack(irq_ack), .svc_done(svc_done),
    .pend(pend_w), .in_svc(isr_w)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_req = '0;
    logic       nest_mode = 1'b0;
    logic       irq_ack = 1'b0;
    logic       svc_done = 1'b0;
    logic       irq_out;
    logic [1:0] irq_id;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    prio_irq_ctrl #(.NSRC(4)) u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .nest_mode(nest_mode),
        .irq_ack(irq_ack), .svc_done(svc_done), .irq_out(irq_out), .irq_id(irq_id)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_src(input logic [3:0] m);
        src_req = m; tick(); src_req = '0;
    endtask

    // wait for a request, check its number, acknowledge it
    task automatic expect_issue(input int exp, input string req);
        int n = 0;
        while (!irq_out && n < 12) begin tick(); n++; end
        check(irq_out, req, int'(irq_out), 1);
        check(irq_id == 2'(exp), req, int'(irq_id), exp);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        check(!irq_out, "R3", int'(irq_out), 0);
    endtask

    task automatic finish_svc();
        svc_done = 1'b1; tick(); svc_done = 1'b0;
    endtask

    task automatic quiet(input int n, input string req);
        repeat (n) tick();
        check(!irq_out, req, int'(irq_out), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(); tick();
        check(!irq_out, "R1", int'(irq_out), 0);
        rst_n = 1'b1;
        tick();
        quiet(3, "R1");

        // R3 exact latency and hold
        src_req = 4'b0100; tick();
        check(!irq_out, "R3", int'(irq_out), 0);
        src_req = '0; tick();
        check(irq_out && irq_id == 2'd2, "R3", int'(irq_id), 2);
        repeat (3) tick();
        check(irq_out && irq_id == 2'd2, "R3", int'(irq_id), 2);
        expect_issue(2, "R3");
        finish_svc();

        // R2 held level does not re-trigger
        src_req = 4'b0010;
        expect_issue(1, "R2");
        finish_svc();
        quiet(6, "R2");
        src_req = '0; tick();

        // R9 stray acknowledge and end-of-service in idle
        irq_ack = 1'b1; svc_done = 1'b1; tick();
        irq_ack = 1'b0; svc_done = 1'b0;
        quiet(3, "R9");
        pulse_src(4'b0001);
        expect_issue(0, "R9");
        finish_svc();

        // R6 same-cycle masks, descending number order (R4 encoding)
        for (int m = 1; m < 16; m++) begin
            pulse_src(4'(m));
            for (int b = 3; b >= 0; b--)
                if (m[b]) begin
                    expect_issue(b, "R6");
                    finish_svc();
                end
        end

        // R5 staggered arrivals, issued in arrival order
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++)
              for (int d = 0; d < 4; d++) begin
                if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
                src_req = 4'(1 << a); tick();
                src_req = src_req | 4'(1 << b); tick();
                src_req = src_req | 4'(1 << c); tick();
                src_req = src_req | 4'(1 << d); tick();
                src_req = '0;
                expect_issue(a, "R5");
                irq_ack = 1'b1; tick(); irq_ack = 1'b0;
                quiet(2, "R5");
                finish_svc();
                expect_issue(b, "R5"); finish_svc();
                expect_issue(c, "R5"); finish_svc();
                expect_issue(d, "R5"); finish_svc();
              end

        // R7 nested pairs
        nest_mode = 1'b1; tick();
        for (int lo = 0; lo < 4; lo++)
            for (int hi = 0; hi < 4; hi++) begin
                if (hi == lo) continue;
                pulse_src(4'(1 << lo));
                expect_issue(lo, "R7");
                pulse_src(4'(1 << hi));
                repeat (4) tick();
                check(irq_out == (hi > lo), "R7", int'(irq_out), int'(hi > lo));
                if (hi > lo) begin
                    expect_issue(hi, "R7");
                    finish_svc();
                    finish_svc();
                end else begin
                    finish_svc();
                    expect_issue(hi, "R7");
                    finish_svc();
                end
                quiet(2, "R7");
            end

        // R8 return to the interrupted level
        pulse_src(4'b0010); expect_issue(1, "R8");
        pulse_src(4'b1000); expect_issue(3, "R8");
        finish_svc();
        pulse_src(4'b0001);
        quiet(4, "R8");
        finish_svc();
        expect_issue(0, "R8"); finish_svc();

        pulse_src(4'b0001); expect_issue(0, "R8");
        pulse_src(4'b0100); expect_issue(2, "R8");
        pulse_src(4'b1000); expect_issue(3, "R8");
        finish_svc();
        pulse_src(4'b0010);
        quiet(4, "R8");
        finish_svc();
        expect_issue(1, "R8");
        finish_svc(); finish_svc();
        quiet(3, "R8");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule